// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of a network interface, between the byte stream coming off the line and the buffers that take frames into memory. It reads the destination address at the head of every frame. It then forwards or discards the whole frame. A frame passes when its destination equals the station's own address, equals the all-ones broadcast value, or matches one of the valid entries in a small multicast table. Every other frame is removed from the stream, including its end marker.

The header bytes are held in a short internal queue while the decision is pending. Once the last destination byte arrives, the held bytes are either released or dropped. With contiguous input, forwarded traffic leaves at a fixed delay. Two free-running counters report how many frames were accepted and how many were dropped. Multicast entries are written one at a time through an index/address/valid write port.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, out_valid is low, both counters read zero, and every multicast entry is invalid, so a frame to any multicast address is dropped.
- R2: The destination is the first 6 bytes of a frame, and the first byte is the most significant byte of the 48-bit address. A frame whose destination equals own_addr comes out byte for byte unchanged, with out_sof on its first byte and out_eof on its last.
- R3: A frame whose destination is all ones (FF:FF:FF:FF:FF:FF) is forwarded whatever the table holds.
- R4: A frame is forwarded when its destination equals the address of a multicast entry whose valid bit is set. Clearing that valid bit makes later frames to that address be dropped.
- R5: A frame whose destination matches no acceptable address produces no output byte at all. A difference in the first byte alone, or in the last byte alone, is enough to cause the drop.
- R6: A frame that ends before its 6th byte, including a one-byte frame with in_sof and in_eof together, is dropped and counted as dropped.
- R7: With contiguous input, each forwarded byte is valid at the output 6 clock edges after the edge that sampled it, and a frame's output bytes are contiguous.
- R8: Bytes presented with in_valid while no frame is open (no in_sof seen since the last end) are ignored: they produce no output and no count.
- R9: acc_count or drop_count rises by one for each frame decided. The new value is visible after the edge that samples the deciding byte, which is the 6th byte or an early end.
- R10: A multicast write with mc_wr_en updates entry mc_wr_idx on that edge and affects frames decided afterwards. A write whose index is not below MC_DEPTH is ignored.
- R11: An in_sof that arrives while a header is still being collected drops the partial frame, counts it as dropped, and starts a new frame with that byte.
- R12: A frame of exactly 6 bytes, whose end marker is on the deciding byte, is forwarded whole when it matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_addr | input | 8*ADDR_BYTES | Station unicast address |
| mc_wr_en | input | 1 | Multicast table write strobe |
| mc_wr_idx | input | IDX_W | Entry index to write |
| mc_wr_addr | input | 8*ADDR_BYTES | Address stored in the entry |
| mc_wr_valid | input | 1 | Valid bit stored in the entry |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a forwarded frame |
| out_eof | output | 1 | Last byte of a forwarded frame |
| acc_count | output | CNT_W | Frames accepted, wrapping |
| drop_count | output | CNT_W | Frames dropped, wrapping |

## Verification
The counters are due one edge after the deciding byte is sampled, so each scenario reads them only after the frame has ended and the queue has drained. The first forwarded byte is due 6 edges after the first header byte is sampled, and each later byte one edge after the previous one. The latency scenario stamps every output byte with a cycle number and compares it with that schedule. The other scenarios wait a fixed drain window longer than the 6-cycle delay and then compare the whole collected output stream with the expected frames.

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int MC_DEPTH   = 4,
  parameter int CNT_W      = 16,
  localparam int AW        = 8 * ADDR_BYTES,
  localparam int IDX_W     = (MC_DEPTH > 1) ? $clog2(MC_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    own_addr,
  input  logic             mc_wr_en,
  input  logic [IDX_W-1:0] mc_wr_idx,
  input  logic [AW-1:0]    mc_wr_addr,
  input  logic             mc_wr_valid,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [CNT_W-1:0] acc_count,
  output logic [CNT_W-1:0] drop_count
);

  localparam int HW  = AW - 8;
  localparam int PW  = $clog2(2 * ADDR_BYTES + 1);
  localparam int FD  = 1 << PW;
  localparam int HCW = $clog2(ADDR_BYTES + 1);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_FWD, S_DROP} st_t;

  st_t            state;
  logic [HCW-1:0] hcnt;
  logic [HW-1:0]  hdr_sr;
  logic [PW-1:0]  wptr, rptr, cptr, hstart;
  logic [9:0]     fifo_q [FD];

  logic [AW-1:0]       mc_tab [MC_DEPTH];
  logic [MC_DEPTH-1:0] mc_vld;
  logic [MC_DEPTH-1:0] mc_hit;

  logic [AW-1:0] dest;
  logic [HW+7:0] shift_cat;
  logic start, hdr_beat, last_hdr, decide, hit, hdr_drop, restart_drop, single;
  logic wr_en;
  logic [PW-1:0] wr_at, fill;

  assign dest         = {hdr_sr, in_data};
  assign shift_cat    = {hdr_sr, in_data};
  assign start        = in_valid && in_sof;
  assign hdr_beat     = in_valid && !in_sof && (state == S_HDR);
  assign last_hdr     = hdr_beat && (hcnt == HCW'(ADDR_BYTES - 1));
  assign decide       = last_hdr;
  assign hit          = (dest == own_addr) || (&dest) || (|mc_hit);
  assign hdr_drop     = hdr_beat && (last_hdr ? !hit : in_eof);
  assign restart_drop = start && (state == S_HDR);
  assign single       = start && in_eof;
  assign wr_at        = restart_drop ? hstart : wptr;
  assign wr_en        = in_valid && (start || state == S_HDR || state == S_FWD);
  assign fill         = wptr - rptr;

  for (genvar g = 0; g < MC_DEPTH; g++) begin : g_mc
    assign mc_hit[g] = mc_vld[g] && (mc_tab[g] == dest);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mc_vld <= '0;
    else if (mc_wr_en && int'(mc_wr_idx) < MC_DEPTH) mc_vld[mc_wr_idx] <= mc_wr_valid;
  end

  always_ff @(posedge clk) begin
    if (mc_wr_en && int'(mc_wr_idx) < MC_DEPTH) mc_tab[mc_wr_idx] <= mc_wr_addr;
  end

  always_ff @(posedge clk) begin
    if (wr_en) fifo_q[wr_at] <= {start, in_eof, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      hcnt   <= '0;
      hdr_sr <= '0;
      wptr   <= '0;
      cptr   <= '0;
      hstart <= '0;
    end else if (start) begin
      hdr_sr <= shift_cat[HW-1:0];
      hstart <= wr_at;
      if (in_eof) begin
        wptr  <= wr_at;
        state <= S_IDLE;
      end else begin
        wptr  <= wr_at + PW'(1);
        hcnt  <= HCW'(1);
        state <= S_HDR;
      end
    end else if (in_valid) begin
      case (state)
        S_HDR: begin
          if (last_hdr) begin
            if (hit) begin
              wptr  <= wptr + PW'(1);
              cptr  <= wptr + PW'(1);
              state <= in_eof ? S_IDLE : S_FWD;
            end else begin
              wptr  <= hstart;
              state <= in_eof ? S_IDLE : S_DROP;
            end
          end else if (in_eof) begin
            wptr  <= hstart;
            state <= S_IDLE;
          end else begin
            wptr   <= wptr + PW'(1);
            hcnt   <= hcnt + HCW'(1);
            hdr_sr <= shift_cat[HW-1:0];
          end
        end
        S_FWD: begin
          wptr <= wptr + PW'(1);
          cptr <= wptr + PW'(1);
          if (in_eof) state <= S_IDLE;
        end
        S_DROP: if (in_eof) state <= S_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else if (rptr != cptr) begin
      {out_sof, out_eof, out_data} <= fifo_q[rptr];
      out_valid <= 1'b1;
      rptr      <= rptr + PW'(1);
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_count  <= '0;
      drop_count <= '0;
    end else begin
      if (decide && hit) acc_count <= acc_count + CNT_W'(1);
      drop_count <= drop_count + CNT_W'(hdr_drop) + CNT_W'(restart_drop) + CNT_W'(single);
    end
  end

endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk #(
  parameter int AW         = 48,
  parameter int CNT_W      = 16,
  parameter int PW         = 4,
  parameter int ADDR_BYTES = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof,
  input logic [CNT_W-1:0] acc_count,
  input logic [CNT_W-1:0] drop_count,
  input logic             decide,
  input logic             hit,
  input logic [AW-1:0]    dest,
  input logic             hdr_beat,
  input logic             last_hdr,
  input logic             in_eof,
  input logic [PW-1:0]    fill
);

  logic open_q;
  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= 1'b0;
    else if (out_valid) open_q <= !out_eof;
  end

  a_r3_bcast_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && (&dest)) |=> acc_count == $past(acc_count) + CNT_W'(1));

  a_r5_miss_not_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !hit) |=> acc_count == $past(acc_count));

  a_r6_runt_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_beat && !last_hdr && in_eof) |=> drop_count == $past(drop_count) + CNT_W'(1));

  a_r9_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |=> acc_count == $past(acc_count));

  a_r2_sof_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> !open_q);

  a_r2_body_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> open_q);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= 2 * ADDR_BYTES);

endmodule

bind rx_dest_filter rx_dest_filter_chk #(
  .AW(AW), .CNT_W(CNT_W), .PW(PW), .ADDR_BYTES(ADDR_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sof(out_sof),
  .out_eof(out_eof), .acc_count(acc_count), .drop_count(drop_count),
  .decide(decide), .hit(hit), .dest(dest), .hdr_beat(hdr_beat),
  .last_hdr(last_hdr), .in_eof(in_eof), .fill(fill)
);

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;
  localparam int AB = 6;
  localparam int MCD = 3;
  localparam int AW = 8 * AB;
  localparam int CW = 16;
  localparam logic [AW-1:0] OWN = 48'h02_11_22_33_44_55;
  localparam logic [AW-1:0] MCA = 48'h01_00_5E_7F_00_21;

  typedef logic [7:0] bq_t[$];

  logic clk = 0, rst_n = 0;
  logic mc_wr_en = 0, mc_wr_valid = 0;
  logic [1:0] mc_wr_idx = 0;
  logic [AW-1:0] mc_wr_addr = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  logic [CW-1:0] acc_count, drop_count;

  int checks = 0, fails = 0, cyc = 0, start_cyc = 0;
  int exp_acc = 0, exp_drop = 0;
  logic [9:0] obs[$], expq[$];
  int obs_cyc[$];
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_dest_filter #(.ADDR_BYTES(AB), .MC_DEPTH(MCD), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .mc_wr_en(mc_wr_en),
    .mc_wr_idx(mc_wr_idx), .mc_wr_addr(mc_wr_addr), .mc_wr_valid(mc_wr_valid),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .acc_count(acc_count), .drop_count(drop_count));

  always @(negedge clk) if (rst_n && out_valid) begin
    obs.push_back({out_sof, out_eof, out_data});
    obs_cyc.push_back(cyc);
  end

  function automatic bq_t mk(input logic [AW-1:0] da, input int len);
    bq_t q;
    for (int i = 0; i < len; i++)
      q.push_back(i < AB ? da[AW-1-8*i -: 8] : 8'(i * 13 + len));
    return q;
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: %s", req, msg); end
  endtask

  task automatic send(input bq_t q, input bit sof, input bit eof);
    foreach (q[i]) begin
      @(negedge clk);
      if (i == 0) start_cyc = cyc;
      in_valid = 1; in_data = q[i];
      in_sof = sof && i == 0; in_eof = eof && i == q.size() - 1;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic expect_frame(input bq_t q);
    foreach (q[i]) expq.push_back({i == 0, i == q.size() - 1, q[i]});
  endtask

  task automatic settle(input string req);
    repeat (14) @(negedge clk);
    begin
      int bad = -1;
      if (obs.size() == expq.size())
        foreach (obs[i]) if (bad < 0 && obs[i] != expq[i]) bad = i;
      check(obs.size() == expq.size() && bad < 0, req,
        $sformatf("stream got %0d entries exp %0d, first mismatch at %0d", obs.size(), expq.size(), bad));
    end
    check(acc_count == CW'(exp_acc) && drop_count == CW'(exp_drop), req,
      $sformatf("counters got acc=%0d drop=%0d exp acc=%0d drop=%0d", acc_count, drop_count, exp_acc, exp_drop));
    obs.delete(); obs_cyc.delete(); expq.delete();
  endtask

  task automatic mc_write(input int idx, input logic [AW-1:0] a, input bit v);
    @(negedge clk);
    mc_wr_en = 1; mc_wr_idx = 2'(idx); mc_wr_addr = a; mc_wr_valid = v;
    @(negedge clk);
    mc_wr_en = 0;
  endtask

  task automatic t_reset();
    check(out_valid == 0, "R1", $sformatf("out_valid got %0b exp 0", out_valid));
    check(acc_count == 0 && drop_count == 0, "R1",
      $sformatf("counters got %0d/%0d exp 0/0", acc_count, drop_count));
  endtask

  task automatic t_unicast();
    bq_t f = mk(OWN, 14);
    send(f, 1, 1); expect_frame(f); exp_acc++;
    settle("R2 R9 unicast");
  endtask

  task automatic t_latency();
    bq_t f = mk(OWN, 10);
    int bad = 0;
    send(f, 1, 1); exp_acc++;
    repeat (14) @(negedge clk);
    if (obs_cyc.size() != 10) bad = 1;
    else foreach (obs_cyc[i]) if (obs_cyc[i] != start_cyc + 7 + i) bad = 1;
    check(!bad, "R7", $sformatf("first out cycle got %0d exp %0d, bytes %0d exp 10",
      obs_cyc.size() ? obs_cyc[0] : -1, start_cyc + 7, obs_cyc.size()));
    obs.delete(); obs_cyc.delete();
    settle("R7 counters");
  endtask

  task automatic t_bcast();
    bq_t f = mk('1, 9);
    send(f, 1, 1); expect_frame(f); exp_acc++;
    settle("R3 broadcast");
  endtask

  task automatic t_miss();
    send(mk(OWN ^ 48'h01, 11), 1, 1); exp_drop++;
    send(mk(OWN ^ 48'h80_00_00_00_00_00, 8), 1, 1); exp_drop++;
    send(mk(48'hFF_FF_FF_FF_FF_FE, 8), 1, 1); exp_drop++;
    settle("R5 miss");
  endtask

  task automatic t_multicast();
    bq_t f = mk(MCA, 12);
    send(f, 1, 1); exp_drop++;
    settle("R1 R4 table empty");
    mc_write(1, MCA, 1);
    send(f, 1, 1); expect_frame(f); exp_acc++;
    settle("R4 R10 entry valid");
    mc_write(3, 48'h01_00_5E_00_00_09, 1);
    send(mk(48'h01_00_5E_00_00_09, 8), 1, 1); exp_drop++;
    settle("R10 out-of-range index");
    mc_write(1, MCA, 0);
    send(f, 1, 1); exp_drop++;
    settle("R4 entry cleared");
  endtask

  task automatic t_runt();
    send(mk(OWN, 4), 1, 1); exp_drop++;
    send(mk(OWN, 1), 1, 1); exp_drop++;
    settle("R6 runt");
  endtask

  task automatic t_stray();
    send(mk(OWN, 9), 0, 1);
    send(mk('1, 7), 0, 0);
    settle("R8 stray bytes");
  endtask

  task automatic t_restart();
    bq_t p = mk(OWN, 3);
    bq_t f = mk(OWN, 10);
    bq_t both;
    foreach (p[i]) both.push_back(p[i]);
    foreach (f[i]) both.push_back(f[i]);
    foreach (both[i]) begin
      @(negedge clk);
      in_valid = 1; in_data = both[i];
      in_sof = (i == 0 || i == 3); in_eof = (i == both.size() - 1);
    end
    @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0;
    expect_frame(f); exp_acc++; exp_drop++;
    settle("R11 restart");
  endtask

  task automatic t_six_and_burst();
    bq_t a = mk(OWN, 6);
    bq_t b = mk(OWN ^ 48'h10, 9);
    bq_t c = mk('1, 7);
    send(a, 1, 1); expect_frame(a); exp_acc++;
    settle("R12 six-byte frame");
    send(a, 1, 1); send(b, 1, 1); send(c, 1, 1);
    expect_frame(a); expect_frame(c); exp_acc += 2; exp_drop++;
    settle("R2 R5 back-to-back");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_latency();
    t_bcast();
    t_miss();
    t_multicast();
    t_runt();
    t_stray();
    t_restart();
    t_six_and_burst();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule